// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a processor. A host programs it over a byte-wide bus that has two ports: a command port and a data port. Programming starts with a short sequence of setup bytes. The sequence sets the vector base, the cascade byte and the end-of-interrupt style. After that, data-port writes load the mask register, and command-port writes issue end-of-interrupt and priority-rotation commands.

Requests are detected either on rising edges or by level. The block picks the highest-priority unmasked request. It raises the interrupt output only when that request outranks every interrupt that is already in service. When the processor acknowledges, the block returns an 8-bit vector. In normal mode the winning request moves into the in-service register. In automatic end-of-interrupt mode it is retired at once. Priority is fixed with input 0 highest, or it rotates on command. The cascade byte and the mode bits are stored and brought out for inspection. The block does not drive a cascade bus.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, int_out is low, the mask register reads 0 and the in-service register reads 0. int_out stays low, whatever the request inputs do, until the setup sequence has completed.
- R2: A command-port write with bit 4 set starts setup. It clears the mask, the in-service register, the pending requests and any rotation. The data-port bytes that follow are taken in this order: the vector base; then the cascade byte, only if bit 1 of the start byte was clear; then the mode byte, only if bit 0 of the start byte was set. Once the last expected byte arrives, the next data-port write loads the mask. The cascade byte appears on casc_cfg. The mode byte appears on op_mode as {bit4, bit3, bit2, bit0}, and its bit 1 selects automatic end-of-interrupt.
- R3: ack_vector is {base[7:3], n}, where n is the number of the winning input. The low three bits of the base byte are ignored.
- R4: When bit 3 of the start byte is clear, requests are edge-sensitive. A 0-to-1 transition latches a request. An input that stays high after its request has been acknowledged raises no new request.
- R5: When bit 3 of the start byte is set, requests are level-sensitive. The pending request follows the input, so a request that drops before acknowledge withdraws int_out. An input that is still high after its end-of-interrupt requests again.
- R6: After setup, a data-port write loads the mask and a data-port read returns it. A set mask bit keeps that input from raising int_out. A request latched while masked is presented once the bit is cleared.
- R7: int_out is high when the highest-priority unmasked pending request outranks every in-service input. Acknowledge while int_out is high clears that request and sets its in-service bit. A command-port read returns the in-service register.
- R8: After setup, priority is fixed, with input 0 highest and input 7 lowest.
- R9: A command-port write with bit 4 clear is an operation command. Bits 7:5 give the opcode and bits 2:0 give an input number L. Opcode 001 clears the highest-priority in-service bit. Opcode 011 clears in-service bit L. Opcode 010 changes nothing.
- R10: Opcode 110 makes input L the lowest priority. Opcode 101 clears the highest-priority in-service bit and makes that input the lowest priority. Opcode 111 clears in-service bit L and makes L the lowest priority. Priority then runs upward from L+1, wrapping modulo 8.
- R11: In automatic end-of-interrupt mode, acknowledge leaves the in-service register unchanged. Opcode 100 enables rotation on acknowledge in this mode: the acknowledged input becomes the lowest priority. Opcode 000 disables that rotation.
- R12: Acknowledge while int_out is low changes no state. ack_vector then reads {base[7:3], 3'b111}.
- R13: When an acknowledge and an end-of-interrupt command fall in the same cycle, the command acts on the in-service register as it was before that cycle, and the acknowledged bit is still set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_port | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mask (data port) or in-service register (command port) |
| irq_in | input | 8 | Request inputs |
| int_out | output | 1 | Interrupt to the processor |
| int_ack | input | 1 | Acknowledge strobe |
| ack_vector | output | 8 | Vector for the current winner |
| casc_cfg | output | 8 | Stored cascade byte |
| op_mode | output | 4 | Stored mode bits |

## Verification
Two things can land in the same clock edge: the processor's acknowledge, which sets an in-service bit, and a host end-of-interrupt command, which clears one. The bench sets up this collision on purpose. With input 3 in service, it raises input 1, which outranks it. It then drives int_ack and a non-specific end-of-interrupt write in the same cycle. After that edge, the in-service register must hold only bit 1. The old bit 3 must be gone, and the newly acknowledged bit must survive the clear.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int IRQ_N = 8;
  localparam int IDW   = $clog2(IRQ_N);
  localparam int BW    = 8;
  localparam int HIW   = BW - IDW;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_BASE, SQ_CASC, SQ_MODE, SQ_RUN
  } seq_t;

  typedef enum logic [2:0] {
    OP_ROT_AUTO_OFF = 3'd0,
    OP_EOI_NS       = 3'd1,
    OP_NOP          = 3'd2,
    OP_EOI_SP       = 3'd3,
    OP_ROT_AUTO_ON  = 3'd4,
    OP_ROT_EOI_NS   = 3'd5,
    OP_SET_LOW      = 3'd6,
    OP_ROT_EOI_SP   = 3'd7
  } op_t;

  function automatic logic [IRQ_N-1:0] onehot_of(input logic [IDW-1:0] id);
    logic [IRQ_N-1:0] v;
    v = '0;
    v[id] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_port,
  input  logic [BW-1:0]   bus_wdata,
  output logic            icw1_evt,
  output logic            mask_evt,
  output logic            ocw2_evt,
  output logic            ready,
  output logic            level_mode,
  output logic            auto_eoi,
  output logic [HIW-1:0]  vec_hi,
  output logic [BW-1:0]   casc_cfg,
  output logic [3:0]      mode_bits
);
  seq_t state_q;
  logic single_q, need_mode_q;
  logic data_evt;

  assign icw1_evt = bus_wr & ~bus_port & bus_wdata[4];
  assign data_evt = bus_wr & bus_port;
  assign ready    = (state_q == SQ_RUN);
  assign mask_evt = data_evt & ready;
  assign ocw2_evt = bus_wr & ~bus_port & ~bus_wdata[4] & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      level_mode  <= 1'b0;
      auto_eoi    <= 1'b0;
      vec_hi      <= '0;
      casc_cfg    <= '0;
      mode_bits   <= '0;
    end else if (icw1_evt) begin
      state_q     <= SQ_BASE;
      level_mode  <= bus_wdata[3];
      single_q    <= bus_wdata[1];
      need_mode_q <= bus_wdata[0];
      auto_eoi    <= 1'b0;
      casc_cfg    <= '0;
      mode_bits   <= '0;
    end else if (data_evt) begin
      unique case (state_q)
        SQ_BASE: begin
          vec_hi <= bus_wdata[BW-1:IDW];
          if (!single_q)       state_q <= SQ_CASC;
          else if (need_mode_q) state_q <= SQ_MODE;
          else                 state_q <= SQ_RUN;
        end
        SQ_CASC: begin
          casc_cfg <= bus_wdata;
          state_q  <= need_mode_q ? SQ_MODE : SQ_RUN;
        end
        SQ_MODE: begin
          auto_eoi  <= bus_wdata[1];
          mode_bits <= {bus_wdata[4], bus_wdata[3:2], bus_wdata[0]};
          state_q   <= SQ_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
#(
  parameter int N = IRQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level_mode,
  input  logic         clr_all,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        irr[g]    <= 1'b0;
      end else begin
        prev_q[g] <= req_in[g];
        if (clr_all)
          irr[g] <= 1'b0;
        else if (level_mode)
          irr[g] <= req_in[g] & ~ack_clr[g];
        else
          irr[g] <= (irr[g] & ~ack_clr[g]) | (req_in[g] & ~prev_q[g]);
      end
    end
  end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
  import pic_pkg::*;
#(
  parameter int N  = IRQ_N,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] lowest,
  output logic          found,
  output logic [LW-1:0] id,
  output logic [LW-1:0] rank
);
  always_comb begin
    found = 1'b0;
    id    = '0;
    rank  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [LW-1:0] idx;
      idx = lowest + LW'(k + 1);
      if (vec[idx]) begin
        found = 1'b1;
        id    = idx;
        rank  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_port,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    irq_in,
  output logic          int_out,
  input  logic          int_ack,
  output logic [7:0]    ack_vector,
  output logic [7:0]    casc_cfg,
  output logic [3:0]    op_mode
);
  logic icw1_evt, mask_evt, ocw2_evt, ready, level_mode, auto_eoi;
  logic [HIW-1:0] vec_hi;

  logic [IRQ_N-1:0] mask_q, isr_q, irr, pending, ack_clr, eoi_clr, isr_set;
  logic [IDW-1:0]   lowest_q;
  logic             rot_auto_q;

  logic           req_found, isr_found, ack_take;
  logic [IDW-1:0] req_id, req_rank, isr_id, isr_rank;
  op_t            op;
  logic [IDW-1:0] op_lvl;

  pic_init_seq u_seq (
    .clk, .rst_n, .bus_wr, .bus_port, .bus_wdata,
    .icw1_evt, .mask_evt, .ocw2_evt, .ready, .level_mode, .auto_eoi,
    .vec_hi, .casc_cfg, .mode_bits(op_mode)
  );

  pic_req_latch #(.N(IRQ_N)) u_req (
    .clk, .rst_n, .level_mode, .clr_all(icw1_evt),
    .req_in(irq_in), .ack_clr, .irr
  );

  assign pending = irr & ~mask_q;

  pic_prio_pick #(.N(IRQ_N)) u_pick_req (
    .vec(pending), .lowest(lowest_q),
    .found(req_found), .id(req_id), .rank(req_rank)
  );

  pic_prio_pick #(.N(IRQ_N)) u_pick_isr (
    .vec(isr_q), .lowest(lowest_q),
    .found(isr_found), .id(isr_id), .rank(isr_rank)
  );

  assign int_out  = ready & req_found & (~isr_found | (req_rank < isr_rank));
  assign ack_take = int_ack & int_out;
  assign ack_clr  = ack_take ? onehot_of(req_id) : '0;
  assign isr_set  = (ack_take & ~auto_eoi) ? onehot_of(req_id) : '0;

  assign ack_vector = {vec_hi, int_out ? req_id : IDW'(IRQ_N - 1)};
  assign bus_rdata  = bus_port ? mask_q : isr_q;

  assign op     = op_t'(bus_wdata[7:5]);
  assign op_lvl = bus_wdata[IDW-1:0];

  always_comb begin
    eoi_clr = '0;
    if (ocw2_evt) begin
      unique case (op)
        OP_EOI_NS, OP_ROT_EOI_NS: if (isr_found) eoi_clr = onehot_of(isr_id);
        OP_EOI_SP, OP_ROT_EOI_SP: eoi_clr = onehot_of(op_lvl);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      isr_q      <= '0;
      lowest_q   <= IDW'(IRQ_N - 1);
      rot_auto_q <= 1'b0;
    end else if (icw1_evt) begin
      mask_q     <= '0;
      isr_q      <= '0;
      lowest_q   <= IDW'(IRQ_N - 1);
      rot_auto_q <= 1'b0;
    end else begin
      if (mask_evt) mask_q <= bus_wdata;
      isr_q <= (isr_q & ~eoi_clr) | isr_set;
      if (ocw2_evt) begin
        unique case (op)
          OP_ROT_AUTO_OFF: rot_auto_q <= 1'b0;
          OP_ROT_AUTO_ON:  rot_auto_q <= 1'b1;
          OP_SET_LOW, OP_ROT_EOI_SP: lowest_q <= op_lvl;
          OP_ROT_EOI_NS:   if (isr_found) lowest_q <= isr_id;
          default: ;
        endcase
      end else if (ack_take && auto_eoi && rot_auto_q) begin
        lowest_q <= req_id;
      end
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       int_out,
  input logic       int_ack,
  input logic       ready,
  input logic       auto_eoi,
  input logic       icw1_evt,
  input logic       ocw2_evt,
  input logic       ack_take,
  input logic [7:0] isr_q,
  input logic [7:0] mask_q
);
  p_quiet_until_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  p_setup_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_evt |=> (isr_q == 8'h00 && mask_q == 8'h00 && !int_out));

  p_ack_sets_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !auto_eoi && !bus_wr) |=> $onehot(isr_q & ~$past(isr_q)));

  p_ns_eoi_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2_evt && bus_wdata[7:5] == 3'b001 && isr_q != 8'h00 && !ack_take)
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  p_auto_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && auto_eoi && !bus_wr) |=> $stable(isr_q));

  p_spurious_no_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out && !bus_wr) |=> $stable(isr_q));
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .int_out(int_out), .int_ack(int_ack), .ready(ready), .auto_eoi(auto_eoi),
  .icw1_evt(icw1_evt), .ocw2_evt(ocw2_evt), .ack_take(ack_take),
  .isr_q(isr_q), .mask_q(mask_q)
);

// File: tb/test_pic8_ctrl.sv
`timescale 1ns/1ps
module test_pic8_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_port = 1'b0, int_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] bus_rdata, ack_vector, casc_cfg;
  logic [3:0] op_mode;
  logic       int_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pic8_ctrl i_pic8_ctrl (
    .clk, .rst_n, .bus_wr, .bus_port, .bus_wdata, .bus_rdata,
    .irq_in, .int_out, .int_ack, .ack_vector, .casc_cfg, .op_mode
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d);
    bus_wr = 1'b1; bus_port = p; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic p, output logic [7:0] d);
    bus_port = p;
    #0.1 d = bus_rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 int_out after reset", {7'b0, int_out}, 8'h00);
    rd(1'b1, d); chk("R1 mask after reset", d, 8'h00);
    rd(1'b0, d); chk("R1 isr after reset", d, 8'h00);
    set_irq(8'h01);
    chk("R1 no int before setup", {7'b0, int_out}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_setup_single();
    wr(1'b0, 8'h13); wr(1'b1, 8'h27); wr(1'b1, 8'h01);
    chk("R2 mode bits", {4'b0, op_mode}, 8'h01);
    chk("R2 no stale request", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    set_irq(8'h08);
    chk("R4 edge raises int", {7'b0, int_out}, 8'h01);
    chk("R3 vector base+3", ack_vector, 8'h23);
    ack();
    rd(1'b0, d); chk("R7 isr after ack", d, 8'h08);
    chk("R7 int low after ack", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h63);
    repeat (3) @(negedge clk);
    chk("R4 held input no re-request", {7'b0, int_out}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_nest();
    logic [7:0] d;
    set_irq(8'h20);
    chk("R7 vector 5", ack_vector, 8'h25);
    ack();
    set_irq(8'h60);
    chk("R7 lower blocked", {7'b0, int_out}, 8'h00);
    set_irq(8'h64);
    chk("R8 higher preempts", {7'b0, int_out}, 8'h01);
    chk("R8 vector 2", ack_vector, 8'h22);
    ack();
    rd(1'b0, d); chk("R7 nested isr", d, 8'h24);
    chk("R7 6 below 2", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 ns eoi clears top", d, 8'h20);
    chk("R7 6 below 5", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h40);
    rd(1'b0, d); chk("R9 nop", d, 8'h20);
    wr(1'b0, 8'h20);
    chk("R9 int after eoi", {7'b0, int_out}, 8'h01);
    chk("R9 vector 6", ack_vector, 8'h26);
    ack();
    wr(1'b0, 8'h66);
    rd(1'b0, d); chk("R9 specific eoi", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1'b1, 8'h10);
    rd(1'b1, d); chk("R6 mask readback", d, 8'h10);
    set_irq(8'h10);
    chk("R6 masked blocked", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R6 unmask presents", {7'b0, int_out}, 8'h01);
    chk("R6 vector 4", ack_vector, 8'h24);
    ack(); wr(1'b0, 8'h64); set_irq(8'h00);
  endtask

  task automatic t_rotate();
    logic [7:0] d;
    wr(1'b0, 8'hC2);
    set_irq(8'h09);
    chk("R10 set low 2: 3 wins", ack_vector, 8'h23);
    ack();
    chk("R10 0 below 3", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'hA0);
    rd(1'b0, d); chk("R10 rotate ns eoi isr", d, 8'h00);
    chk("R10 vector 0", ack_vector, 8'h20);
    ack();
    set_irq(8'h8B);
    chk("R10 7 outranks 0", ack_vector, 8'h27);
    ack();
    rd(1'b0, d); chk("R10 isr 0 and 7", d, 8'h81);
    wr(1'b0, 8'hE7);
    rd(1'b0, d); chk("R10 rotate sp eoi", d, 8'h01);
    chk("R10 fixed again: 1 below 0", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h60);
    chk("R10 vector 1", ack_vector, 8'h21);
    ack(); wr(1'b0, 8'h61); set_irq(8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h1B); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R2 setup clears mask", d, 8'h00);
    set_irq(8'h40);
    chk("R5 level vector", ack_vector, 8'h46);
    set_irq(8'h00);
    chk("R5 drop withdraws", {7'b0, int_out}, 8'h00);
    set_irq(8'h40);
    ack();
    chk("R5 in service", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h66);
    chk("R5 re-request after eoi", {7'b0, int_out}, 8'h01);
    ack(); set_irq(8'h00); wr(1'b0, 8'h66);
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    chk("R12 spurious vector", ack_vector, 8'h47);
    ack();
    rd(1'b0, d); chk("R12 isr unchanged", d, 8'h00);
    chk("R12 int low", {7'b0, int_out}, 8'h00);
  endtask

  task automatic t_auto();
    logic [7:0] d;
    wr(1'b0, 8'h13); wr(1'b1, 8'h80); wr(1'b1, 8'h03);
    set_irq(8'h04);
    chk("R11 vector 2", ack_vector, 8'h82);
    ack();
    rd(1'b0, d); chk("R11 auto keeps isr", d, 8'h00);
    set_irq(8'h00);
    wr(1'b0, 8'h80);
    set_irq(8'h10); ack(); set_irq(8'h00);
    set_irq(8'h28);
    chk("R11 rotated: 5 over 3", ack_vector, 8'h85);
    ack();
    wr(1'b0, 8'h00);
    chk("R11 vector 3", ack_vector, 8'h83);
    ack(); set_irq(8'h00);
    set_irq(8'h50);
    chk("R11 rotation off: 6 over 4", ack_vector, 8'h86);
    ack();
    chk("R11 vector 4", ack_vector, 8'h84);
    ack(); set_irq(8'h00);
  endtask

  task automatic t_cascade();
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R2 cascade byte", casc_cfg, 8'h04);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R2 mask after mode byte", d, 8'hFF);
    wr(1'b0, 8'h10); wr(1'b1, 8'h08); wr(1'b1, 8'h02); wr(1'b1, 8'h33);
    chk("R2 cascade no mode", casc_cfg, 8'h02);
    rd(1'b1, d); chk("R2 mode byte skipped", d, 8'h33);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    set_irq(8'h08);
    chk("R3 vector base 08", ack_vector, 8'h0B);
    ack();
    set_irq(8'h0A);
    chk("R13 1 preempts 3", {7'b0, int_out}, 8'h01);
    int_ack = 1'b1; bus_wr = 1'b1; bus_port = 1'b0; bus_wdata = 8'h20;
    @(negedge clk);
    int_ack = 1'b0; bus_wr = 1'b0;
    rd(1'b0, d); chk("R13 eoi before ack", d, 8'h02);
    wr(1'b0, 8'h61); set_irq(8'h00);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_single();
    t_edge();
    t_nest();
    t_mask();
    t_rotate();
    t_level();
    t_spurious();
    t_auto();
    t_cascade();
    t_same_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule